// File: doc/BRIEF.md
# Multi-Cycle Shared-ALU Processor Datapath

This block is the storage and arithmetic half of a 32-bit processor that takes several clock cycles per instruction. A single ALU and a single unified memory port serve every step of an instruction. Values that one step produces for a later step of the same instruction wait in hidden latches: the instruction register, the memory data register, two operand latches and an ALU result latch. The block also holds the program counter and a 32-entry register file with two read ports and one write port.

The block makes no decisions of its own. An external sequencer drives a load enable for every internal register and a select for every input multiplexer, cycle by cycle. The select codes are the ALU operand A source, the ALU operand B source, the ALU operation, the next-PC source, the memory address source, the write-back register and the write-back data. The datapath gives the opcode and function fields of the instruction register back to that sequencer. Memory reads are combinational from the address the block drives, and memory writes happen at the clock edge while the write strobe is high.

Top module: `multicycle_datapath`

## Requirements
- R1: While `rstN` is low, the PC is set to `RESET_PC` (default 0). The instruction register, the memory data register, the A latch, the B latch, the ALU result latch and all register-file entries are cleared. `memWe` is low.
- R2: With `memAddrSel`=0, `memAddr` is the PC. With `irWrite`=1 the instruction register captures `memRData`, and `instrOp`/`instrFunct` then show its bits [31:26] and [5:0]. Suppose `aluSrcA`=0 (PC), `aluSrcB`=1 (constant 4), `aluOp`=ADD, `pcSrc`=0 (ALU result) and `pcWrite`=1. The PC then becomes PC+4.
- R3: With `aWrite`/`bWrite` set, the A latch takes register[IR[25:21]] and the B latch takes register[IR[20:16]]. Suppose `aluSrcA`=0, `aluSrcB`=3 and `aluOp`=ADD. The ALU result latch then takes the PC plus the sign-extended IR[15:0] shifted left by two.
- R4: `aluOp` selects the operation: 3'b010 add, 3'b110 subtract, 3'b000 AND, 3'b001 OR, 3'b111 signed set-less-than (result 1 or 0). The zero flag is high when the result is all zeros.
- R5: With `aluSrcA`=1 (A) and `aluSrcB`=2 (sign-extended IR[15:0]), the ALU forms A plus the offset, which may be negative. `memAddrSel`=1 drives the ALU result latch onto `memAddr`. `memWe` follows `memWrite`, and `memWData` is the B latch.
- R6: `mdrWrite` captures `memRData` into the memory data register. `regWrite` with `memToReg`=1 and `regDst`=0 writes that register into register[IR[20:16]].
- R7: `regWrite` with `memToReg`=0 and `regDst`=1 writes the ALU result latch into register[IR[15:11]] and leaves register[IR[20:16]] untouched.
- R8: With `pcWriteCond`=1 and `pcSrc`=1, the PC loads the ALU result latch only when the ALU zero flag is high (A equal to B under subtract). Otherwise the PC keeps its value.
- R9: With `pcSrc`=2 and `pcWrite`=1, the PC loads {PC[31:28], IR[25:0], 2'b00}.
- R10: Register 0 reads as zero, and writes to it, from the ALU result or from memory, have no effect.
- R11: A register whose load enable is low keeps its value across any number of cycles. This covers the PC when both `pcWrite` and `pcWriteCond` are low, and the ALU result latch while the ALU computes other values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| memRData | input | 32 | Word read from memory at `memAddr` |
| memAddr | output | 32 | Memory byte address (PC or ALU result latch) |
| memWData | output | 32 | Store data (B latch) |
| memWe | output | 1 | Memory write strobe |
| instrOp | output | 6 | Instruction register bits [31:26] |
| instrFunct | output | 6 | Instruction register bits [5:0] |
| pcWrite | input | 1 | Unconditional PC load |
| pcWriteCond | input | 1 | PC load qualified by the ALU zero flag |
| irWrite | input | 1 | Instruction register load |
| mdrWrite | input | 1 | Memory data register load |
| aWrite | input | 1 | A latch load |
| bWrite | input | 1 | B latch load |
| aluOutWrite | input | 1 | ALU result latch load |
| regWrite | input | 1 | Register file write |
| memWrite | input | 1 | Store request, passed to `memWe` |
| memAddrSel | input | 1 | 0: PC, 1: ALU result latch onto `memAddr` |
| aluSrcA | input | 1 | 0: PC, 1: A latch |
| aluSrcB | input | 2 | 0: B latch, 1: constant 4, 2: sign-extended immediate, 3: immediate shifted left by two |
| aluOp | input | 3 | ALU operation code (see R4) |
| pcSrc | input | 2 | 0: ALU result, 1: ALU result latch, 2 or 3: jump target |
| regDst | input | 1 | 0: IR[20:16], 1: IR[15:11] as write register |
| memToReg | input | 1 | 0: ALU result latch, 1: memory data register as write data |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 32 registers and a reset PC of zero. With these values the first fetch lands at address zero, and a 16-bit immediate with bit 15 set reaches both the negative load/store offset and the backward branch. The jump's upper four PC bits stay zero, so jump targets can be predicted exactly. The bench acts as the sequencer and drives load, store, register-register, branch and jump step sequences. A scoreboard checks every fetch address and every store it predicts from its own register and PC model.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;
  localparam int XLEN    = 32;
  localparam int REG_NUM = 32;
  localparam int REG_AW  = $clog2(REG_NUM);
  localparam int IMM_W   = 16;
  localparam int JIDX_W  = 26;
  localparam int FIELD_W = 6;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } aluOp_e;

  localparam logic [1:0] SRCB_REG  = 2'd0;
  localparam logic [1:0] SRCB_FOUR = 2'd1;
  localparam logic [1:0] SRCB_IMM  = 2'd2;
  localparam logic [1:0] SRCB_OFS  = 2'd3;

  localparam logic [1:0] PCS_ALU  = 2'd0;
  localparam logic [1:0] PCS_HELD = 2'd1;
  localparam logic [1:0] PCS_JUMP = 2'd2;

  typedef struct packed {
    logic       irLoad;
    logic       mdrLoad;
    logic       aLoad;
    logic       bLoad;
    logic       aluOutLoad;
    logic       regLoad;
    logic       memWr;
    logic       addrFromAluOut;
    logic       srcAFromReg;
    logic [1:0] srcBSel;
    logic [2:0] aluOp;
    logic [1:0] pcSel;
    logic       dstIsRd;
    logic       wbFromMdr;
  } strobes_t;
endpackage

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result,
  output logic         zero
);
  logic lessThan;

  always_comb begin
    lessThan = $signed(opA) < $signed(opB);
    unique case (op)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_SLT: result = W'(lessThan);
      default: result = '0;
    endcase
    zero = (result == '0);
  end

  always_comb begin
    if (op == ALU_SUB) begin
      AST_SUB_ZERO: assert ((opA == opB) == zero); // R4
    end
  end
endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile
  import mcdp_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = REG_NUM,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData,
  input  logic          wrEn,
  output logic [W-1:0]  rdDataA,
  output logic [W-1:0]  rdDataB
);
  logic [W-1:0] regs [1:N-1];

  for (genvar g = 1; g < N; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regs[g] <= '0;
      else if (wrEn && wrAddr == AW'(g)) regs[g] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];
endmodule

// File: rtl/mcdp_strobes.sv
module mcdp_strobes
  import mcdp_pkg::*;
(
  input  logic     pcWrite,
  input  logic     pcWriteCond,
  input  logic     irWrite,
  input  logic     mdrWrite,
  input  logic     aWrite,
  input  logic     bWrite,
  input  logic     aluOutWrite,
  input  logic     regWrite,
  input  logic     memWrite,
  input  logic     memAddrSel,
  input  logic     aluSrcA,
  input  logic [1:0] aluSrcB,
  input  logic [2:0] aluOp,
  input  logic [1:0] pcSrc,
  input  logic     regDst,
  input  logic     memToReg,
  input  logic     aluZero,
  output strobes_t st,
  output logic     pcLoad
);
  always_comb begin
    st.irLoad         = irWrite;
    st.mdrLoad        = mdrWrite;
    st.aLoad          = aWrite;
    st.bLoad          = bWrite;
    st.aluOutLoad     = aluOutWrite;
    st.regLoad        = regWrite;
    st.memWr          = memWrite;
    st.addrFromAluOut = memAddrSel;
    st.srcAFromReg    = aluSrcA;
    st.srcBSel        = aluSrcB;
    st.aluOp          = aluOp;
    st.pcSel          = pcSrc;
    st.dstIsRd        = regDst;
    st.wbFromMdr      = memToReg;
  end

  // A conditional PC load is granted only when the ALU reports equality.
  assign pcLoad = pcWrite | (pcWriteCond & aluZero);
endmodule

// File: rtl/mcdp_datapath.sv
module mcdp_datapath
  import mcdp_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           st,
  input  logic               pcLoad,
  input  logic [XLEN-1:0]    memRData,
  output logic [XLEN-1:0]    memAddr,
  output logic [XLEN-1:0]    memWData,
  output logic               memWe,
  output logic [FIELD_W-1:0] instrOp,
  output logic [FIELD_W-1:0] instrFunct,
  output logic               aluZero
);
  localparam int TOP_KEEP = XLEN - JIDX_W - 2;

  logic [XLEN-1:0] pc, ir, mdr, aReg, bReg, aluOut;
  logic [XLEN-1:0] signExt, srcA, srcB, aluRes, jumpTarget, pcNext;
  logic [XLEN-1:0] rfA, rfB, wbData;
  logic [REG_AW-1:0] wbAddr;

  assign signExt    = {{(XLEN-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
  assign jumpTarget = {pc[XLEN-1 -: TOP_KEEP], ir[JIDX_W-1:0], 2'b00};

  // Operand selection for the single shared ALU.
  always_comb begin
    srcA = st.srcAFromReg ? aReg : pc;
    unique case (st.srcBSel)
      SRCB_REG:  srcB = bReg;
      SRCB_FOUR: srcB = XLEN'(4);
      SRCB_IMM:  srcB = signExt;
      default:   srcB = signExt << 2;
    endcase
  end

  mcdp_alu #(.W(XLEN)) uAlu (
    .op    (st.aluOp),
    .opA   (srcA),
    .opB   (srcB),
    .result(aluRes),
    .zero  (aluZero)
  );

  always_comb begin
    unique case (st.pcSel)
      PCS_ALU:  pcNext = aluRes;
      PCS_HELD: pcNext = aluOut;
      default:  pcNext = jumpTarget;
    endcase
  end

  assign wbAddr = st.dstIsRd ? ir[15:11] : ir[20:16];
  assign wbData = st.wbFromMdr ? mdr : aluOut;

  mcdp_regfile #(.W(XLEN), .N(REG_NUM)) uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .rdAddrA(ir[25:21]),
    .rdAddrB(ir[20:16]),
    .wrAddr (wbAddr),
    .wrData (wbData),
    .wrEn   (st.regLoad),
    .rdDataA(rfA),
    .rdDataB(rfB)
  );

  // Architectural PC and the hidden per-instruction latches.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc     <= RESET_PC;
      ir     <= '0;
      mdr    <= '0;
      aReg   <= '0;
      bReg   <= '0;
      aluOut <= '0;
    end else begin
      if (pcLoad)        pc     <= pcNext;
      if (st.irLoad)     ir     <= memRData;
      if (st.mdrLoad)    mdr    <= memRData;
      if (st.aLoad)      aReg   <= rfA;
      if (st.bLoad)      bReg   <= rfB;
      if (st.aluOutLoad) aluOut <= aluRes;
    end
  end

  assign memAddr    = st.addrFromAluOut ? aluOut : pc;
  assign memWData   = bReg;
  assign memWe      = st.memWr;
  assign instrOp    = ir[XLEN-1 -: FIELD_W];
  assign instrFunct = ir[FIELD_W-1:0];

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pcLoad |=> $stable(pc)); // R11

  AST_MDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !st.mdrLoad |=> $stable(mdr)); // R11

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && st.pcSel == PCS_ALU && !st.srcAFromReg &&
     st.srcBSel == SRCB_FOUR && st.aluOp == ALU_ADD)
    |=> pc == $past(pc) + XLEN'(4)); // R2

  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (st.aluOutLoad && !st.srcAFromReg && st.srcBSel == SRCB_OFS &&
     st.aluOp == ALU_ADD)
    |=> aluOut == $past(pc) + ($past(signExt) << 2)); // R3

  AST_JUMP_FORM: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && st.pcSel == PCS_JUMP)
    |=> (pc[1:0] == 2'b00 && pc[XLEN-1 -: TOP_KEEP] == $past(pc[XLEN-1 -: TOP_KEEP]))); // R9

  AST_RT0_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (st.bLoad && ir[20:16] == '0) |=> bReg == '0); // R10
endmodule

// File: rtl/multicycle_datapath.sv
module multicycle_datapath
  import mcdp_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [XLEN-1:0]    memRData,
  output logic [XLEN-1:0]    memAddr,
  output logic [XLEN-1:0]    memWData,
  output logic               memWe,
  output logic [FIELD_W-1:0] instrOp,
  output logic [FIELD_W-1:0] instrFunct,
  input  logic               pcWrite,
  input  logic               pcWriteCond,
  input  logic               irWrite,
  input  logic               mdrWrite,
  input  logic               aWrite,
  input  logic               bWrite,
  input  logic               aluOutWrite,
  input  logic               regWrite,
  input  logic               memWrite,
  input  logic               memAddrSel,
  input  logic               aluSrcA,
  input  logic [1:0]         aluSrcB,
  input  logic [2:0]         aluOp,
  input  logic [1:0]         pcSrc,
  input  logic               regDst,
  input  logic               memToReg
);
  strobes_t st;
  logic     pcLoad;
  logic     aluZero;

  mcdp_strobes uCtl (
    .pcWrite    (pcWrite),
    .pcWriteCond(pcWriteCond),
    .irWrite    (irWrite),
    .mdrWrite   (mdrWrite),
    .aWrite     (aWrite),
    .bWrite     (bWrite),
    .aluOutWrite(aluOutWrite),
    .regWrite   (regWrite),
    .memWrite   (memWrite),
    .memAddrSel (memAddrSel),
    .aluSrcA    (aluSrcA),
    .aluSrcB    (aluSrcB),
    .aluOp      (aluOp),
    .pcSrc      (pcSrc),
    .regDst     (regDst),
    .memToReg   (memToReg),
    .aluZero    (aluZero),
    .st         (st),
    .pcLoad     (pcLoad)
  );

  mcdp_datapath #(.RESET_PC(RESET_PC)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .pcLoad    (pcLoad),
    .memRData  (memRData),
    .memAddr   (memAddr),
    .memWData  (memWData),
    .memWe     (memWe),
    .instrOp   (instrOp),
    .instrFunct(instrFunct),
    .aluZero   (aluZero)
  );
endmodule

// File: tb/sim_multicycle_datapath.sv
`timescale 1ns/1ps
module sim_multicycle_datapath;
  localparam logic [2:0] OP_AND = 3'b000, OP_OR = 3'b001, OP_ADD = 3'b010,
                         OP_SUB = 3'b110, OP_SLT = 3'b111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] memRData, memAddr, memWData;
  logic        memWe;
  logic [5:0]  instrOp, instrFunct;
  logic pcWrite, pcWriteCond, irWrite, mdrWrite, aWrite, bWrite, aluOutWrite;
  logic regWrite, memWrite, memAddrSel, aluSrcA, regDst, memToReg;
  logic [1:0] aluSrcB, pcSrc;
  logic [2:0] aluOp;

  logic [31:0] mem [256];
  assign memRData = mem[memAddr[9:2]];

  multicycle_datapath u0 (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit monOn = 0;

  // scoreboard queues: one entry per expected fetch or store
  bit          qWr[$];
  logic [31:0] qAddr[$];
  logic [31:0] qData[$];
  string       qTag[$];

  logic [31:0] rf [32];
  logic [31:0] refPc;
  string nextFetchTag = "R2 fetch address";

  function automatic void chk(input bit ok, input string tag,
                              input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic void push(input bit wr, input logic [31:0] a,
                               input logic [31:0] d, input string tag);
    qWr.push_back(wr); qAddr.push_back(a); qData.push_back(d); qTag.push_back(tag);
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] i);
    return {{16{i[15]}}, i};
  endfunction

  function automatic logic [31:0] aluM(input logic [2:0] op, input logic [31:0] a,
                                       input logic [31:0] b);
    case (op)
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_SLT:  return {31'b0, $signed(a) < $signed(b)};
      default: return 32'h0;
    endcase
  endfunction

  // monitor: samples half a nanosecond before each rising edge
  bit          mWr;
  logic [31:0] mA, mD;
  string       mT;
  initial forever begin
    @(negedge clk);
    #2;
    if (monOn && (irWrite || memWe)) begin
      if (qWr.size() == 0) begin
        chk(1'b0, "R5 unexpected memory activity", memAddr, 32'h0);
      end else begin
        mWr = qWr.pop_front(); mA = qAddr.pop_front();
        mD = qData.pop_front(); mT = qTag.pop_front();
        if (mWr != memWe) chk(1'b0, {mT, " write strobe"}, 32'(memWe), 32'(mWr));
        else begin
          chk(memAddr == mA, {mT, " address"}, memAddr, mA);
          if (mWr) chk(memWData == mD, {mT, " data"}, memWData, mD);
        end
      end
    end
  end

  task automatic clr();
    {pcWrite, pcWriteCond, irWrite, mdrWrite, aWrite, bWrite, aluOutWrite} = '0;
    {regWrite, memWrite, memAddrSel, aluSrcA, regDst, memToReg} = '0;
    aluSrcB = 2'd0; pcSrc = 2'd0; aluOp = OP_AND;
  endtask

  // apply memory write just before the edge, then realign to negedge + 1
  task automatic tick();
    #1.25;
    if (memWe) mem[memAddr[9:2]] = memWData;
    @(negedge clk);
    #1;
  endtask

  task automatic doFetch(input logic [31:0] instr);
    mem[refPc[9:2]] = instr;
    clr(); irWrite = 1; pcWrite = 1; aluSrcB = 2'd1; aluOp = OP_ADD;
    push(1'b0, refPc, 32'h0, nextFetchTag);
    nextFetchTag = "R2 fetch address";
    refPc = refPc + 32'd4;
    tick();
  endtask

  task automatic doDecode(input logic [31:0] instr);
    clr(); aWrite = 1; bWrite = 1; aluOutWrite = 1; aluSrcB = 2'd3; aluOp = OP_ADD;
    chk({instrOp, instrFunct} == {instr[31:26], instr[5:0]}, "R2 IR fields",
        32'({instrOp, instrFunct}), 32'({instr[31:26], instr[5:0]}));
    tick();
  endtask

  task automatic lwI(input int rt, input int rs, input logic [15:0] imm,
                     input bit gap, input string tag);
    logic [31:0] w = {6'h23, 5'(rs), 5'(rt), imm};
    logic [31:0] a = rf[rs] + sx(imm);
    logic [31:0] d = mem[a[9:2]];
    doFetch(w); doDecode(w);
    clr(); aluSrcA = 1; aluSrcB = 2'd2; aluOp = OP_ADD; aluOutWrite = 1; tick();
    if (gap) begin
      clr(); aluSrcB = 2'd1; aluOp = OP_SUB; tick();
    end
    clr(); memAddrSel = 1; mdrWrite = 1;
    #0.1;
    chk(memAddr == a, {tag, " load address"}, memAddr, a);
    tick();
    clr(); regWrite = 1; memToReg = 1; tick();
    if (rt != 0) rf[rt] = d;
  endtask

  task automatic swI(input int rt, input int rs, input logic [15:0] imm, input string tag);
    logic [31:0] w = {6'h2B, 5'(rs), 5'(rt), imm};
    doFetch(w); doDecode(w);
    clr(); aluSrcA = 1; aluSrcB = 2'd2; aluOp = OP_ADD; aluOutWrite = 1; tick();
    clr(); memAddrSel = 1; memWrite = 1;
    push(1'b1, rf[rs] + sx(imm), rf[rt], tag);
    tick();
  endtask

  task automatic rI(input int rd, input int rs, input int rt, input logic [2:0] op,
                    input logic [5:0] funct);
    logic [31:0] w = {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, funct};
    doFetch(w); doDecode(w);
    clr(); aluSrcA = 1; aluSrcB = 2'd0; aluOp = op; aluOutWrite = 1; tick();
    clr(); regWrite = 1; regDst = 1; tick();
    if (rd != 0) rf[rd] = aluM(op, rf[rs], rf[rt]);
  endtask

  task automatic beqI(input int rs, input int rt, input logic [15:0] imm);
    logic [31:0] w = {6'h04, 5'(rs), 5'(rt), imm};
    doFetch(w); doDecode(w);
    clr(); aluSrcA = 1; aluSrcB = 2'd0; aluOp = OP_SUB; pcSrc = 2'd1; pcWriteCond = 1; tick();
    if (rf[rs] == rf[rt]) begin
      refPc = refPc + (sx(imm) << 2);
      nextFetchTag = "R3 R8 taken branch target";
    end else begin
      nextFetchTag = "R8 untaken branch falls through";
    end
  endtask

  task automatic jI(input logic [25:0] idx);
    logic [31:0] w = {6'h02, idx};
    doFetch(w); doDecode(w);
    clr(); pcSrc = 2'd2; pcWrite = 1; tick();
    refPc = {refPc[31:28], idx, 2'b00};
    nextFetchTag = "R9 jump target";
  endtask

  task automatic idle(input int n);
    clr();
    repeat (n) tick();
    nextFetchTag = "R11 PC held while enables low";
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int i = 0; i < 32; i++) rf[i] = 32'h0;
    mem[128] = 32'h0000_0005;
    mem[129] = 32'hFFFF_FFF0;
    mem[130] = 32'h0F0F_00FF;
    mem[131] = 32'h7000_0000;
    mem[132] = 32'h0000_0220;
    refPc = 32'h0;
    clr();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: PC at reset address, IR cleared, no store strobe
    chk(memAddr == 32'h0, "R1 reset PC on memAddr", memAddr, 32'h0);
    chk(memWe == 1'b0 && instrOp == 6'h0, "R1 reset strobe and IR",
        32'({memWe, instrOp}), 32'h0);
    monOn = 1;

    lwI(1, 0, 16'h0200, 1'b0, "R5 R6");
    lwI(2, 0, 16'h0204, 1'b0, "R5 R6");
    lwI(3, 0, 16'h0208, 1'b1, "R11 ALUOut held");
    lwI(4, 0, 16'h020C, 1'b0, "R5 R6");
    lwI(7, 0, 16'h0210, 1'b0, "R5 R6");
    swI(15, 0, 16'h0300, "R1 register never written reads zero");
    swI(1, 7, 16'hFFF8, "R5 negative offset store");
    swI(2, 0, 16'h0304, "R6 loaded value in rt");
    rI(8, 1, 2, OP_ADD, 6'h20);
    swI(8, 0, 16'h0308, "R4 R7 add result");
    swI(2, 0, 16'h030C, "R7 rt unchanged by R-type write");
    rI(9, 1, 2, OP_SUB, 6'h22);
    swI(9, 0, 16'h0310, "R4 subtract");
    rI(10, 3, 2, OP_AND, 6'h24);
    swI(10, 0, 16'h0314, "R4 AND");
    rI(11, 3, 4, OP_OR, 6'h25);
    swI(11, 0, 16'h0318, "R4 OR");
    rI(12, 2, 1, OP_SLT, 6'h2A);
    swI(12, 0, 16'h031C, "R4 signed less-than true");
    rI(13, 1, 2, OP_SLT, 6'h2A);
    swI(13, 0, 16'h0320, "R4 signed less-than false");
    rI(0, 1, 1, OP_ADD, 6'h20);
    swI(0, 0, 16'h0324, "R10 r0 after ALU write");
    lwI(0, 0, 16'h0200, 1'b0, "R10 load to r0");
    swI(0, 0, 16'h0328, "R10 r0 after load");
    beqI(1, 1, 16'h0003);
    swI(12, 0, 16'h032C, "R8 store after taken branch");
    beqI(1, 2, 16'h0005);
    swI(13, 0, 16'h0330, "R8 store after untaken branch");
    beqI(9, 9, 16'hFFFC);
    jI(26'h0000040);
    idle(3);
    swI(11, 0, 16'h0334, "R11 store after idle cycles");
    swI(4, 7, 16'h0004, "R5 base plus positive offset");
    idle(2);
    chk(qWr.size() == 0, "R2 all expected fetches and stores seen",
        32'(qWr.size()), 32'h0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R1-R11 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule